// File: doc/BRIEF.md
# Toggle-Addressed Attribute Register Bank

This block holds a small bank of display-attribute registers behind a single shared write port. A hidden phase bit decides how each write is taken. In the index phase the write byte selects a register. In the data phase the write byte is stored into the selected register. Every accepted write flips the phase. A strobe on the separate input-status read line forces the phase back to index, so software can always resynchronise before it starts an index/data pair.

The bank has sixteen 6-bit palette-remap entries, an 8-bit mode register, an 8-bit border (overscan) color, a 4-bit plane-enable mask, a 3-bit pixel-panning value and a 4-bit color-select value. Bit 5 of an index write is kept as the video-enable flag. While that flag is set, the palette entries are locked against writes. A combinational read port returns the register that the current index selects. All register contents are exported as plain outputs for the pixel path downstream. The write port is a plain strobe with no back-pressure: a write is accepted on every clock edge at which `wr_en` is high.

Top module: `attr_port`

## Requirements
- R1: After reset, `data_phase` is 0, `video_on` is 0, `cur_index` is 0 and every register, including all palette entries, reads 0.
- R2: A write in the index phase (`data_phase`=0) loads `wr_data[4:0]` into `cur_index` and `wr_data[5]` into `video_on`, and sets `data_phase` to 1 on the next cycle.
- R3: A write in the data phase stores `wr_data` into the register that `cur_index` selects and clears `data_phase`. The index map is: 0..15 are palette entries (low 6 bits kept), 16 is mode (8 bits), 17 is overscan (8 bits), 18 is plane enable (low 4 bits) and 20 is color select (low 4 bits).
- R4: A high `stat_rd` clears `data_phase` on the next edge. A write in the same cycle is still handled in the phase that held before that edge.
- R5: While `video_on` is 1, data writes to indices 0..15 leave every palette entry unchanged. Writes to indices 16..20 still take effect.
- R6: Index 19 is pixel panning. It keeps only `wr_data[2:0]`.
- R7: `rd_data` always shows the register selected by `cur_index`, zero-extended to 8 bits. Indices 21..31 read 0, and data writes to them change no register.
- R8: Palette entry k appears on `pal_flat[6k+5:6k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe on the shared index/data port |
| wr_data | input | 8 | Write byte |
| stat_rd | input | 1 | Input-status read strobe; forces the index phase |
| rd_data | output | 8 | Contents of the register selected by the current index |
| data_phase | output | 1 | 1 when the next write is taken as data |
| video_on | output | 1 | Video enable from bit 5 of the last index write |
| cur_index | output | 5 | Current register index |
| pal_flat | output | 96 | Sixteen 6-bit palette entries, packed |
| mode_reg | output | 8 | Mode control register |
| overscan | output | 8 | Border color |
| plane_en | output | 4 | Color-plane enable mask |
| pan | output | 3 | Pixel-panning amount |
| color_sel | output | 4 | Color-select register |

## Verification
A table of write and status-read steps walks index/data pairs through every register. The values are chosen so that the upper bits are set on narrow fields, which exposes any wrong truncation and any field that lands at the wrong index. Status reads are placed both between the index and the data write and after a complete pair. This shows whether the strobe re-aligns the phase without touching stored data. Directed steps then set the video bit to check the palette lock against the still-writable control registers. They also cover a write and a status read in the same cycle in both phases, and a reset in the middle of a run.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int DW       = 8;
  localparam int IDX_W    = 5;
  localparam int PAL_N    = 16;
  localparam int PAL_W    = 6;
  localparam int VID_BIT  = 5;
  localparam int PLANE_W  = 4;
  localparam int PAN_W    = 3;
  localparam int CSEL_W   = 4;
  localparam int IX_MODE  = PAL_N;
  localparam int IX_OVSC  = PAL_N + 1;
  localparam int IX_PLANE = PAL_N + 2;
  localparam int IX_PAN   = PAL_N + 3;
  localparam int IX_CSEL  = PAL_N + 4;
  localparam int NREG     = PAL_N + 5;
endpackage

// File: rtl/attr_flipflop.sv
module attr_flipflop (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic stat_rd,
  output logic data_phase
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (stat_rd) phase_q <= 1'b0;
    else if (wr_en)   phase_q <= ~phase_q;
  end

  assign data_phase = phase_q;

  p_stat_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !data_phase);
  p_toggle_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stat_rd) |=> (data_phase != $past(data_phase)));
endmodule

// File: rtl/attr_index_reg.sv
module attr_index_reg #(
  parameter int IDX_W   = attr_pkg::IDX_W,
  parameter int VID_BIT = attr_pkg::VID_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VID_BIT:0] din,
  output logic [IDX_W-1:0] idx,
  output logic             video_on
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      video_on <= 1'b0;
    end else if (load) begin
      idx      <= din[IDX_W-1:0];
      video_on <= din[VID_BIT];
    end
  end

  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == $past(din[IDX_W-1:0])) && (video_on == $past(din[VID_BIT])));
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(idx) && $stable(video_on));
endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank #(
  parameter int DW      = attr_pkg::DW,
  parameter int IDX_W   = attr_pkg::IDX_W,
  parameter int PAL_N   = attr_pkg::PAL_N,
  parameter int PAL_W   = attr_pkg::PAL_W,
  parameter int PLANE_W = attr_pkg::PLANE_W,
  parameter int PAN_W   = attr_pkg::PAN_W,
  parameter int CSEL_W  = attr_pkg::CSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               video_on,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DW-1:0]      din,
  output logic [PAL_N*PAL_W-1:0] pal_flat,
  output logic [DW-1:0]      mode_q,
  output logic [DW-1:0]      ovsc_q,
  output logic [PLANE_W-1:0] plane_q,
  output logic [PAN_W-1:0]   pan_q,
  output logic [CSEL_W-1:0]  csel_q,
  output logic [DW-1:0]      rd_data
);
  import attr_pkg::*;
  localparam int PSEL_W = $clog2(PAL_N);

  logic [PAL_W-1:0] pal_q [PAL_N];

  genvar k;
  generate
    for (k = 0; k < PAL_N; k++) begin : g_pal
      always_ff @(posedge clk) begin
        if (!rst_n)
          pal_q[k] <= '0;
        else if (we && !video_on && idx == IDX_W'(k))
          pal_q[k] <= din[PAL_W-1:0];
      end
      assign pal_flat[k*PAL_W +: PAL_W] = pal_q[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ovsc_q  <= '0;
      plane_q <= '0;
      pan_q   <= '0;
      csel_q  <= '0;
    end else if (we) begin
      case (idx)
        IDX_W'(IX_MODE):  mode_q  <= din;
        IDX_W'(IX_OVSC):  ovsc_q  <= din;
        IDX_W'(IX_PLANE): plane_q <= din[PLANE_W-1:0];
        IDX_W'(IX_PAN):   pan_q   <= din[PAN_W-1:0];
        IDX_W'(IX_CSEL):  csel_q  <= din[CSEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (idx < IDX_W'(PAL_N)) begin
      rd_data = DW'(pal_q[idx[PSEL_W-1:0]]);
    end else begin
      case (idx)
        IDX_W'(IX_MODE):  rd_data = mode_q;
        IDX_W'(IX_OVSC):  rd_data = ovsc_q;
        IDX_W'(IX_PLANE): rd_data = DW'(plane_q);
        IDX_W'(IX_PAN):   rd_data = DW'(pan_q);
        IDX_W'(IX_CSEL):  rd_data = DW'(csel_q);
        default:          rd_data = '0;
      endcase
    end
  end

  p_pal_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    video_on |=> $stable(pal_flat));
  p_bank_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(pal_flat) && $stable(mode_q) && $stable(ovsc_q)
            && $stable(plane_q) && $stable(pan_q) && $stable(csel_q));
endmodule

// File: rtl/attr_port.sv
module attr_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        stat_rd,
  output logic [7:0]  rd_data,
  output logic        data_phase,
  output logic        video_on,
  output logic [4:0]  cur_index,
  output logic [95:0] pal_flat,
  output logic [7:0]  mode_reg,
  output logic [7:0]  overscan,
  output logic [3:0]  plane_en,
  output logic [2:0]  pan,
  output logic [3:0]  color_sel
);
  import attr_pkg::*;

  logic idx_load;
  logic data_we;

  assign idx_load = wr_en && !data_phase;
  assign data_we  = wr_en &&  data_phase;

  attr_flipflop u_ff (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .stat_rd    (stat_rd),
    .data_phase (data_phase)
  );

  attr_index_reg u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (idx_load),
    .din      (wr_data[VID_BIT:0]),
    .idx      (cur_index),
    .video_on (video_on)
  );

  attr_reg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (data_we),
    .video_on (video_on),
    .idx      (cur_index),
    .din      (wr_data),
    .pal_flat (pal_flat),
    .mode_q   (mode_reg),
    .ovsc_q   (overscan),
    .plane_q  (plane_en),
    .pan_q    (pan),
    .csel_q   (color_sel),
    .rd_data  (rd_data)
  );

  p_oob_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_index >= 5'(NREG)) |-> (rd_data == 8'h00));
  p_pan_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && cur_index == 5'(IX_PAN)) |=> (pan == $past(wr_data[2:0])));
endmodule

// File: tb/attr_port_tb.sv
module attr_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        stat_rd;
  logic [7:0]  rd_data;
  logic        data_phase;
  logic        video_on;
  logic [4:0]  cur_index;
  logic [95:0] pal_flat;
  logic [7:0]  mode_reg;
  logic [7:0]  overscan;
  logic [3:0]  plane_en;
  logic [2:0]  pan;
  logic [3:0]  color_sel;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  attr_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .rd_data(rd_data), .data_phase(data_phase),
    .video_on(video_on), .cur_index(cur_index), .pal_flat(pal_flat),
    .mode_reg(mode_reg), .overscan(overscan), .plane_en(plane_en),
    .pan(pan), .color_sel(color_sel)
  );

  // vector: {op[1:0] (0 write, 1 status read), data[7:0], exp_phase, exp_rd[7:0]}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 8'h10, 1'b1, 8'h00},
    {2'd0, 8'hA5, 1'b0, 8'hA5},
    {2'd0, 8'h03, 1'b1, 8'h00},
    {2'd0, 8'hFF, 1'b0, 8'h3F},
    {2'd0, 8'h13, 1'b1, 8'h00},
    {2'd1, 8'h00, 1'b0, 8'h00},
    {2'd0, 8'h12, 1'b1, 8'h00},
    {2'd0, 8'hF9, 1'b0, 8'h09},
    {2'd0, 8'h13, 1'b1, 8'h00},
    {2'd0, 8'hEE, 1'b0, 8'h06},
    {2'd0, 8'h11, 1'b1, 8'h00},
    {2'd0, 8'h5A, 1'b0, 8'h5A},
    {2'd0, 8'h14, 1'b1, 8'h00},
    {2'd0, 8'h7C, 1'b0, 8'h0C},
    {2'd0, 8'h16, 1'b1, 8'h00},
    {2'd0, 8'h77, 1'b0, 8'h00},
    {2'd0, 8'h03, 1'b1, 8'h3F},
    {2'd1, 8'h00, 1'b0, 8'h3F}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, return at the following negedge
  task automatic step(input logic w, input logic s, input logic [7:0] d);
    wr_en = w; stat_rd = s; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; stat_rd = 1'b0; wr_data = 8'h00;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; stat_rd = 1'b0; wr_data = 8'h00;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 phase", data_phase, 0);
    chk("R1 video", video_on, 0);
    chk("R1 index", cur_index, 0);
    chk("R1 rd", rd_data, 0);
    chk("R1 pal", (pal_flat == '0), 1);

    // R2 R3 R4 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18:17] == 2'd0, VEC[i][18:17] == 2'd1, VEC[i][16:9]);
      chk($sformatf("R2/R3 step %0d phase", i), data_phase, VEC[i][8]);
      chk($sformatf("R3/R7 step %0d rd", i), rd_data, VEC[i][7:0]);
    end
    chk("R3 mode", mode_reg, 8'hA5);
    chk("R3 overscan", overscan, 8'h5A);
    chk("R3 plane", plane_en, 4'h9);
    chk("R6 pan", pan, 3'h6);
    chk("R3 color_sel", color_sel, 4'hC);
    chk("R8 entry3", pal_flat[3*6 +: 6], 6'h3F);

    // R5 video enable locks palette
    step(1'b1, 1'b0, 8'h23);
    chk("R2 video_on", video_on, 1);
    chk("R2 index", cur_index, 5'd3);
    step(1'b1, 1'b0, 8'h11);
    chk("R5 palette locked rd", rd_data, 8'h3F);
    chk("R5 palette locked out", pal_flat[3*6 +: 6], 6'h3F);
    step(1'b1, 1'b0, 8'h30);
    step(1'b1, 1'b0, 8'h44);
    chk("R5 mode writable", mode_reg, 8'h44);
    step(1'b1, 1'b0, 8'h00);
    chk("R2 video off", video_on, 0);
    step(1'b1, 1'b0, 8'hEA);
    chk("R8 entry0", pal_flat[5:0], 6'h2A);
    step(1'b1, 1'b0, 8'h0F);
    step(1'b1, 1'b0, 8'h15);
    chk("R8 entry15", pal_flat[15*6 +: 6], 6'h15);

    // R4 simultaneous write and status read
    step(1'b1, 1'b0, 8'h10);
    step(1'b1, 1'b1, 8'h33);
    chk("R4 data write kept", mode_reg, 8'h33);
    chk("R4 phase after data", data_phase, 0);
    step(1'b1, 1'b1, 8'h11);
    chk("R4 index loaded", cur_index, 5'd17);
    chk("R4 phase forced", data_phase, 0);
    step(1'b1, 1'b0, 8'h12);
    chk("R4 next is index", cur_index, 5'd18);
    chk("R4 phase data", data_phase, 1);
    step(1'b0, 1'b0, 8'h00);
    chk("R3 no write no flip", data_phase, 1);

    // R7 out-of-range index reads zero even with data stored
    step(1'b1, 1'b0, 8'h02);
    step(1'b1, 1'b0, 8'h1F);
    chk("R7 oob rd", rd_data, 0);
    chk("R7 oob idx", cur_index, 5'd31);

    // R1 mid-run reset
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk("R1 phase mid", data_phase, 0);
    chk("R1 mode mid", mode_reg, 0);
    chk("R1 pal mid", (pal_flat == '0), 1);
    chk("R1 pan mid", pan, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule